// File: doc/BRIEF.md
# Nibble Entry Register with Serial or Parallel Load

This block is the front stage of a four-bit-wide first-in first-out queue. A nibble is captured in one of two ways. It can be loaded all at once from a parallel bus, or it can be assembled one bit at a time from a serial line that has its own slow shift clock. The register holds the nibble until the downstream stack accepts it. It reports whether it is occupied on an active-low full flag.

Storage is five flip-flops: four data bits and one marker bit. A reset or a stack acknowledge presets a 1 into the top data bit. That 1 walks down the chain as serial bits arrive. It reaches the marker position exactly when the fourth bit has been taken, so no bit counter is needed. While the marker is set, serial clocks are ignored.

Everything runs on one system clock. The serial clock is sampled through a synchronizer, and the serial data line is delayed by the same number of stages so that each bit stays aligned with its clock edge.

Top module: `nib_entry_reg`

## Requirements
- R1: After the asynchronous reset (`rst_n` low), the register reads `dout` = 4'b1000 and `full_n` = 1 (empty).
- R2: A synchronous `mreset` high restores the pattern `dout` = 4'b1000, `full_n` = 1 at the next clock edge. It takes precedence over a parallel load, an acknowledge and a serial shift.
- R3: While `pload` is high, each clock edge copies `pdin` into `dout` (bit i to bit i) and drives `full_n` low. A parallel load takes precedence over a serial shift.
- R4: A falling edge of `sclk` while `sen_n` and `pload` are low shifts the chain one place. `sdin` enters `dout[3]`, each data bit moves one place down, and `dout[0]` moves into the marker. The shifted value appears by the fourth system-clock edge after `sclk` falls.
- R5: After exactly four accepted falling edges, `full_n` goes low. The first serial bit is then in `dout[0]` and the fourth in `dout[3]`. After only three edges, `full_n` is still high.
- R6: While `full_n` is low, falling edges of `sclk` change neither `dout` nor `full_n`.
- R7: While `sen_n` is high, falling edges of `sclk` change neither `dout` nor `full_n`.
- R8: A one-cycle `ack` while `full_n` is low returns the register to `dout` = 4'b1000, `full_n` = 1. An `ack` while `full_n` is high is ignored, and a serial load in progress continues.
- R9: A rising edge of `sclk` changes neither `dout` nor `full_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mreset | input | 1 | Synchronous master reset, active high |
| pload | input | 1 | Parallel load strobe, level sensitive |
| pdin | input | 4 | Parallel nibble input |
| sdin | input | 1 | Serial data input |
| sclk | input | 1 | Serial shift clock; shifts on its falling edge |
| sen_n | input | 1 | Serial enable, active low |
| ack | input | 1 | Transfer acknowledge from the stack |
| dout | output | 4 | Held nibble (or partial serial state) |
| full_n | output | 1 | Active-low full flag |

## Verification
A wrong preset or a wrong shift direction moves the marker to the wrong place. That shows up either as `full_n` falling after the wrong number of serial bits, or as a nibble with its bits reversed or offset. Both are visible at the port within four system clocks of the fourth serial edge. A missing full interlock shows as a changed `dout` a few clocks after an extra `sclk` fall on a full register. A broken acknowledge shows either as a stale nibble on the next cycle, or as a lost partial load that then completes one bit late.

// File: rtl/nib_pkg.sv
package nib_pkg;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned SYNC_STAGES = 2;

  function automatic logic [NIB_W:0] preset_chain();
    logic [NIB_W:0] v;
    v = '0;
    v[NIB_W - 1] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/sclk_fall_det.sv
module sclk_fall_det #(
  parameter int unsigned STAGES = nib_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic sdat_in,
  output logic fall,
  output logic sdat_al
);
  logic [STAGES:0]   clk_pipe_q;
  logic [STAGES-1:0] dat_pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_pipe_q <= '0;
      dat_pipe_q <= '0;
    end else begin
      clk_pipe_q <= {clk_pipe_q[STAGES-1:0], sclk_in};
      dat_pipe_q <= {dat_pipe_q[STAGES-2:0], sdat_in};
    end
  end

  assign fall    = clk_pipe_q[STAGES] & ~clk_pipe_q[STAGES-1];
  assign sdat_al = dat_pipe_q[STAGES-1];
endmodule

// File: rtl/nib_chain.sv
module nib_chain #(
  parameter int unsigned W = nib_pkg::NIB_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mreset,
  input  logic         pload,
  input  logic [W-1:0] pdin,
  input  logic         shift_req,
  input  logic         sbit,
  input  logic         ack,
  output logic [W-1:0] data,
  output logic         mark
);
  localparam logic [W:0] PRESET = nib_pkg::preset_chain();

  logic [W:0] chain_q;
  logic [W:0] chain_d;
  logic       chain_en;
  logic       full;

  assign full = chain_q[W];

  always_comb begin
    chain_d  = chain_q;
    chain_en = 1'b0;
    if (mreset) begin
      chain_d  = PRESET;
      chain_en = 1'b1;
    end else if (ack && full) begin
      chain_d  = PRESET;
      chain_en = 1'b1;
    end else if (pload) begin
      chain_d  = {1'b1, pdin};
      chain_en = 1'b1;
    end else if (shift_req && !full) begin
      chain_d  = {chain_q[0], sbit, chain_q[W-1:1]};
      chain_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= PRESET;
    end else if (chain_en) begin
      chain_q <= chain_d;
    end
  end

  assign data = chain_q[W-1:0];
  assign mark = chain_q[W];
endmodule

// File: rtl/nib_entry_reg.sv
module nib_entry_reg #(
  parameter int unsigned W      = nib_pkg::NIB_W,
  parameter int unsigned STAGES = nib_pkg::SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mreset,
  input  logic         pload,
  input  logic [W-1:0] pdin,
  input  logic         sdin,
  input  logic         sclk,
  input  logic         sen_n,
  input  logic         ack,
  output logic [W-1:0] dout,
  output logic         full_n
);
  logic sclk_fall;
  logic sbit_al;
  logic shift_req;
  logic mark;

  sclk_fall_det #(.STAGES(STAGES)) edge_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_in (sclk),
    .sdat_in (sdin),
    .fall    (sclk_fall),
    .sdat_al (sbit_al)
  );

  assign shift_req = sclk_fall & ~sen_n & ~pload;

  nib_chain #(.W(W)) chain_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mreset    (mreset),
    .pload     (pload),
    .pdin      (pdin),
    .shift_req (shift_req),
    .sbit      (sbit_al),
    .ack       (ack),
    .data      (dout),
    .mark      (mark)
  );

  assign full_n = ~mark;
endmodule

// File: rtl/nib_entry_chk.sv
module nib_entry_chk #(
  parameter int unsigned W = nib_pkg::NIB_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mreset,
  input logic         pload,
  input logic [W-1:0] pdin,
  input logic         ack,
  input logic         sclk,
  input logic         sen_n,
  input logic [W-1:0] dout,
  input logic         full_n
);
  localparam logic [W-1:0] EMPTY_PAT = {1'b1, {(W-1){1'b0}}};

  // R2: master reset wins over every other request
  a_r2_mreset_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    mreset |=> (dout == EMPTY_PAT) && full_n);

  // R3: parallel load captures the bus and marks the register full
  a_r3_pload_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (pload && !mreset && !(ack && !full_n)) |=> (dout == $past(pdin)) && !full_n);

  // R6: a full register with no load, acknowledge or reset keeps its contents
  a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && !mreset && !ack && !pload) |=> $stable(dout) && !full_n);

  // R8: an acknowledge on a full register restores the empty pattern
  a_r8_ack_reinit: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && ack && !mreset) |=> (dout == EMPTY_PAT) && full_n);

  // R7: with the serial enable off and no other request, nothing changes
  a_r7_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sen_n && !mreset && !pload && !ack) |=> $stable(dout) && $stable(full_n));
endmodule

bind nib_entry_reg nib_entry_chk #(.W(W)) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .mreset (mreset),
  .pload  (pload),
  .pdin   (pdin),
  .ack    (ack),
  .sclk   (sclk),
  .sen_n  (sen_n),
  .dout   (dout),
  .full_n (full_n)
);

// File: tb/nib_entry_reg_tb.sv
module nib_entry_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mreset;
  logic       pload;
  logic [3:0] pdin;
  logic       sdin;
  logic       sclk;
  logic       sen_n;
  logic       ack;
  logic [3:0] dout;
  logic       full_n;

  int errs   = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  nib_entry_reg dut_i (
    .clk(clk), .rst_n(rst_n), .mreset(mreset), .pload(pload), .pdin(pdin),
    .sdin(sdin), .sclk(sclk), .sen_n(sen_n), .ack(ack),
    .dout(dout), .full_n(full_n)
  );

  function automatic logic [3:0] serial_nib(input logic [3:0] bits_first_at0);
    return bits_first_at0;
  endfunction

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual {full_n,dout}=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdin = b;
    sclk = 1'b1;
    cyc(4);
    sclk = 1'b0;
    cyc(5);
  endtask

  task automatic send_nib(input logic [3:0] v);
    for (int i = 0; i < 4; i++) send_bit(v[i]);
  endtask

  task automatic do_ack();
    ack = 1'b1;
    cyc(1);
    ack = 1'b0;
    cyc(1);
  endtask

  initial begin
    cyc(150000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] v;
    logic [3:0] junk;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; mreset = 1'b0; pload = 1'b0; pdin = '0;
    sdin = 1'b0; sclk = 1'b0; sen_n = 1'b0; ack = 1'b0;
    cyc(3);
    chk("R1 reset state", {full_n, dout}, 5'b1_1000);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 after release", {full_n, dout}, 5'b1_1000);

    // R3 parallel load
    pdin = 4'b0110; pload = 1'b1; cyc(1); pload = 1'b0; cyc(1);
    chk("R3 parallel load", {full_n, dout}, {1'b0, 4'b0110});
    // R6 extra sclk on full
    send_bit(1'b1); send_bit(1'b0);
    chk("R6 full ignores sclk", {full_n, dout}, {1'b0, 4'b0110});
    // R8 ack
    do_ack();
    chk("R8 ack reinit", {full_n, dout}, 5'b1_1000);

    // R2 mreset beats pload
    pdin = 4'b0101; pload = 1'b1; mreset = 1'b1; cyc(1);
    pload = 1'b0; mreset = 1'b0; cyc(1);
    chk("R2 mreset over pload", {full_n, dout}, 5'b1_1000);

    // R9 rising edge alone does nothing
    sdin = 1'b1; sclk = 1'b1; cyc(6);
    chk("R9 rising sclk ignored", {full_n, dout}, 5'b1_1000);
    sclk = 1'b0; sen_n = 1'b1; cyc(6);
    // R7 disabled serial
    send_nib(4'b1111);
    chk("R7 sen_n high ignores sclk", {full_n, dout}, 5'b1_1000);
    sen_n = 1'b0;

    // R5 three bits not full, fourth completes
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    checks++;
    if (full_n !== 1'b1) begin
      errs++;
      $display("FAIL R5 three bits: actual full_n=%b expected 1", full_n);
    end
    send_bit(1'b1);
    chk("R5 bit order 1001", {full_n, dout}, {1'b0, serial_nib(4'b1001)});
    do_ack();

    // R8 ack while empty is ignored mid-load
    send_bit(1'b0); send_bit(1'b1);
    do_ack();
    send_bit(1'b1); send_bit(1'b0);
    chk("R8 ack empty ignored", {full_n, dout}, {1'b0, 4'b0110});
    do_ack();

    // R2 mreset mid serial load
    send_bit(1'b1); send_bit(1'b1);
    mreset = 1'b1; cyc(1); mreset = 1'b0; cyc(1);
    chk("R2 mreset mid serial", {full_n, dout}, 5'b1_1000);

    // Random mix: R3 R4 R5 R6 R8
    for (int it = 0; it < 40; it++) begin
      v = 4'($urandom());
      junk = 4'($urandom());
      if ($urandom_range(1, 0) == 1) begin
        pdin = v; pload = 1'b1; cyc(1 + $urandom_range(2, 0)); pload = 1'b0; cyc(1);
        chk("R3 random parallel", {full_n, dout}, {1'b0, v});
      end else begin
        send_nib(v);
        chk("R4 R5 random serial", {full_n, dout}, {1'b0, serial_nib(v)});
      end
      for (int k = 0; k < 1 + int'($urandom_range(2, 0)); k++) send_bit(junk[k]);
      chk("R6 random full hold", {full_n, dout}, {1'b0, v});
      do_ack();
      chk("R8 random ack", {full_n, dout}, 5'b1_1000);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule